// File: doc/BRIEF.md
# Token-Ring Deep FIFO Chain

This block joins several small FIFO segments into one deeper FIFO. The segments share one write port and one read port. Address width does not grow with depth. Instead, a write token and a read token travel around the ring of segments. Only the segment that holds the write token accepts the shared write strobe. Only the segment that holds the read token accepts the shared read strobe.

When a segment fills its last physical location, it raises its expansion-out line for that one cycle, and the write token moves to the next segment. When a segment drains its last physical location, it raises the same line, and the read token moves on. The next segment then resumes at its own location zero, and the last segment hands back to the first.

An active-low first-load vector chooses which segment holds both tokens when reset ends. Composite full and empty flags are formed from the flags of every segment. Retransmit and half-full have no meaning in this arrangement, so they are not provided.

Top module: `dx_fifo_chain`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `empty` is 1, `full` is 0, `rd_valid` is 0 and `exp_out` is all zero. Every segment pointer returns to location zero.
- R2: Words leave in the order they were accepted, across every segment boundary. `rd_data` carries the word, and `rd_valid` is 1 in the cycle after the clock edge that accepted the read.
- R3: A write is accepted at a rising clock edge when `wr_en` is 1 and `full` is 0. When `full` is 1, the write is ignored, and that word never appears on `rd_data`.
- R4: A read is accepted when `rd_en` is 1 and `empty` is 0. When `empty` is 1, the read is ignored and `rd_valid` stays 0 in the next cycle.
- R5: `full` is 1 exactly when the chain holds SEGMENTS*SEG_DEPTH words. `empty` is 1 exactly when the chain holds none. Both flags are valid in the cycle after each edge.
- R6: During a cycle in which segment i accepts a write into its last physical location, bit i of `exp_out` is 1. The value is combinational from the strobe.
- R7: During a cycle in which segment i accepts a read from its last physical location, bit i of `exp_out` is 1.
- R8: The pulse of R6 moves the write token from segment i to segment (i+1) mod SEGMENTS. The pulse of R7 moves the read token in the same way. The receiving segment's next access goes to its location zero, with no dead cycle. Each segment therefore holds SEG_DEPTH consecutive words per lap.
- R9: The two tokens move independently. In one cycle, a write and a read are both accepted when `full` and `empty` are both 0, and the write token may lead the read token by several segments.
- R10: After reset, the segment whose `first_n` bit is 0 holds both tokens. The first write and the first read go to its location zero, so its bit is the first to pulse in `exp_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| first_n | input | SEGMENTS | First-load select; the bit at 0 marks the starting segment |
| wr_en | input | 1 | Shared write strobe |
| wr_data | input | WIDTH | Write word |
| rd_en | input | 1 | Shared read strobe |
| rd_data | output | WIDTH | Read word, registered |
| rd_valid | output | 1 | `rd_data` holds a word read at the previous edge |
| full | output | 1 | Composite full flag |
| empty | output | 1 | Composite empty flag |
| exp_out | output | SEGMENTS | Expansion-out pulse of each segment |

## Verification
Each cycle of stimulus has a fixed timing. `exp_out` responds within the strobe cycle itself, so the bench samples it one time unit after driving inputs on the falling edge. `full` and `empty` reflect the edge just passed and are sampled in the next low phase. `rd_data` and `rd_valid` appear one cycle after the accepting edge, and a monitor samples them two time units after the rising edge. The bench models the word count and the position of each token itself. From that model it predicts, ahead of every edge, whether the write and the read will be accepted and which `exp_out` bit must pulse. The runs start from two different first-load segments, include overfill and overdrain, and stream several laps of the ring.

// File: rtl/dx_fifo_chain.sv
module dx_fifo_chain #(
  parameter int WIDTH     = 9,
  parameter int SEG_DEPTH = 8,
  parameter int SEGMENTS  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SEGMENTS-1:0] first_n,
  input  logic                wr_en,
  input  logic [WIDTH-1:0]    wr_data,
  input  logic                rd_en,
  output logic [WIDTH-1:0]    rd_data,
  output logic                rd_valid,
  output logic                full,
  output logic                empty,
  output logic [SEGMENTS-1:0] exp_out
);
  localparam int AW = $clog2(SEG_DEPTH);
  localparam logic [AW-1:0] LAST = AW'(SEG_DEPTH - 1);

  logic [SEGMENTS-1:0] wtok, rtok, seg_full, seg_empty;
  logic [SEGMENTS-1:0] wr_hit, rd_hit, wlast, rlast;
  logic [WIDTH-1:0]    seg_rd [SEGMENTS];
  logic [WIDTH-1:0]    rd_sel;

  for (genvar i = 0; i < SEGMENTS; i++) begin : g_seg
    localparam int PREV = (i + SEGMENTS - 1) % SEGMENTS;
    logic [AW:0]      wptr, rptr;
    logic [WIDTH-1:0] mem [SEG_DEPTH];

    assign seg_empty[i] = (wptr == rptr);
    assign seg_full[i]  = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
    assign wr_hit[i]    = wr_en && wtok[i] && !seg_full[i];
    assign rd_hit[i]    = rd_en && rtok[i] && !seg_empty[i];
    assign wlast[i]     = wr_hit[i] && (wptr[AW-1:0] == LAST);
    assign rlast[i]     = rd_hit[i] && (rptr[AW-1:0] == LAST);
    assign exp_out[i]   = wlast[i] | rlast[i];
    assign seg_rd[i]    = mem[rptr[AW-1:0]];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wptr    <= '0;
        rptr    <= '0;
        wtok[i] <= !first_n[i];
        rtok[i] <= !first_n[i];
      end else begin
        if (wr_hit[i]) begin
          mem[wptr[AW-1:0]] <= wr_data;
          wptr <= wptr + 1'b1;
        end
        if (rd_hit[i]) rptr <= rptr + 1'b1;
        wtok[i] <= (wtok[i] && !wlast[i]) || wlast[PREV];
        rtok[i] <= (rtok[i] && !rlast[i]) || rlast[PREV];
      end
    end
  end

  always_comb begin
    rd_sel = '0;
    for (int k = 0; k < SEGMENTS; k++)
      if (rd_hit[k]) rd_sel = rd_sel | seg_rd[k];
  end

  assign full  = &seg_full;
  assign empty = &seg_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= |rd_hit;
      if (|rd_hit) rd_data <= rd_sel;
    end
  end
endmodule

// File: rtl/dx_fifo_chain_chk.sv
module dx_fifo_chain_chk #(
  parameter int SEGMENTS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic                rd_en,
  input logic                rd_valid,
  input logic                full,
  input logic                empty,
  input logic [SEGMENTS-1:0] exp_out,
  input logic [SEGMENTS-1:0] wtok,
  input logic [SEGMENTS-1:0] rtok
);
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (empty && !full && !rd_valid));

  a_r2_valid_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en));

  a_r3_full_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_en) |-> (exp_out == '0));

  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    empty |=> !rd_valid);

  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !empty);

  a_r8_single_tokens: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wtok) && $onehot0(rtok));

  a_r6_idle_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !rd_en) |-> (exp_out == '0));
endmodule

bind dx_fifo_chain dx_fifo_chain_chk #(.SEGMENTS(SEGMENTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
  .rd_valid(rd_valid), .full(full), .empty(empty), .exp_out(exp_out),
  .wtok(wtok), .rtok(rtok)
);

// File: tb/dx_fifo_chain_test.sv
module dx_fifo_chain_test;
  localparam int W = 9, D = 8, N = 4, CAP = N * D;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [N-1:0] first_n = '1;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic rd_valid, full, empty;
  logic [N-1:0] exp_out;

  dx_fifo_chain #(.WIDTH(W), .SEG_DEPTH(D), .SEGMENTS(N)) uut (
    .clk(clk), .rst_n(rst_n), .first_n(first_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .full(full),
    .empty(empty), .exp_out(exp_out));

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [W-1:0] q[$];
  int cnt, wseg, widx, rseg, ridx;
  logic rd_due = 0;
  logic mon_on = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, expv, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (mon_on) begin
      chk(rd_valid == rd_due, "R4 rd_valid", rd_valid, rd_due);
      if (rd_valid && rd_due) begin
        if (q.size() == 0) chk(0, "R2 unexpected word", rd_data, 0);
        else begin
          logic [W-1:0] e;
          e = q.pop_front();
          chk(rd_data == e, "R2 order", rd_data, e);
        end
      end
    end
  end

  task automatic do_reset(input int start);
    @(negedge clk);
    mon_on = 0; rst_n = 0; wr_en = 0; rd_en = 0;
    first_n = '1; first_n[start] = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(empty == 1 && full == 0 && rd_valid == 0 && exp_out == '0, "R1 reset state",
        {empty, full, rd_valid, exp_out}, {3'b100, {N{1'b0}}});
    rst_n = 1;
    cnt = 0; wseg = start; rseg = start; widx = 0; ridx = 0;
    q.delete(); rd_due = 0;
    @(negedge clk);
    #1;
    chk(empty == 1 && full == 0 && rd_valid == 0, "R1 after release",
        {empty, full, rd_valid}, 3'b100);
    mon_on = 1;
  endtask

  task automatic cyc(input bit w, input bit r);
    bit wacc, racc;
    logic [N-1:0] ev;
    @(negedge clk);
    wr_en = w; rd_en = r; wr_data = W'($urandom);
    #1;
    chk(full == (cnt == CAP), "R5 full", full, cnt == CAP);
    chk(empty == (cnt == 0), "R5 empty", empty, cnt == 0);
    wacc = w && (cnt < CAP);
    racc = r && (cnt > 0);
    ev = '0;
    if (wacc && widx == D - 1) ev[wseg] = 1'b1;
    if (racc && ridx == D - 1) ev[rseg] = 1'b1;
    chk(exp_out == ev, "R6 R7 R8 R10 exp_out", exp_out, ev);
    if (wacc) begin
      q.push_back(wr_data);
      if (widx == D - 1) begin widx = 0; wseg = (wseg + 1) % N; end else widx++;
    end
    if (racc) begin
      if (ridx == D - 1) begin ridx = 0; rseg = (rseg + 1) % N; end else ridx++;
    end
    cnt = cnt + int'(wacc) - int'(racc);
    rd_due = racc;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset(0);
    // R3: overfill, R5: full after CAP writes
    for (int i = 0; i < CAP + 3; i++) cyc(1, 0);
    // R9: read and write together at full; write rejected, read accepted
    cyc(1, 1);
    cyc(0, 0);
    // R4: overdrain
    for (int i = 0; i < CAP + 3; i++) cyc(0, 1);
    cyc(0, 0);
    // R9: simultaneous streaming, several laps
    for (int i = 0; i < 20; i++) cyc(1, 0);
    for (int i = 0; i < 200; i++) cyc(1, 1);
    for (int i = 0; i < 3000; i++) cyc($urandom_range(0, 9) < 7, $urandom_range(0, 9) < 6);
    for (int i = 0; i < CAP + 2; i++) cyc(0, 1);
    // R10: start from segment 2, wrap past last segment
    do_reset(2);
    for (int i = 0; i < 3 * D; i++) cyc(1, 0);
    for (int i = 0; i < 2000; i++) cyc($urandom_range(0, 9) < 5, $urandom_range(0, 9) < 5);
    for (int i = 0; i < CAP + 2; i++) cyc(0, 1);
    cyc(0, 0);
    @(negedge clk);
    chk(q.size() == 0, "R2 all words drained", q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule